// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level

This block buffers characters arriving from a UART receiver until the host collects them. Every slot holds one received byte together with three per-character condition flags (parity error, framing error, break). The receiver pushes through a write strobe; the host sees the oldest character at all times and removes it with a read strobe.

An 8-bit control word programs the block. It sets the queue enable, a two-bit trigger code, a one-shot receive flush, and a one-shot transmit flush that is only forwarded to a neighbouring transmit queue. The block raises a data request once the fill level reaches the programmed trigger threshold. It keeps a summary error flag that stays high while any stored character carries a condition flag. When the queue is disabled it behaves as a single-character holding register.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty and disabled, the trigger code is 00, and dataReq, fifoErr, overrun, txFlush and hostValid are all 0.
- R2: When enabled, characters leave in arrival order with their flags intact. hostValid is 1 exactly when fillLevel is nonzero. fillLevel counts the stored characters, up to DEPTH (16).
- R3: When enabled, ctrlData[7:6] selects the threshold: 00 gives 1, 01 gives DEPTH/4 (4), 10 gives DEPTH/2 (8) and 11 gives DEPTH-2 (14). dataReq is 1 while fillLevel is at or above the threshold.
- R4: A push into a full queue is discarded and leaves the contents unchanged. overrun is 1 for the single cycle after the discarded push.
- R5: Writing ctrlData[1]=1 empties the queue and its error tally, and fillLevel reads 0 from the second cycle after the write. The flush bit clears itself, so later pushes are stored normally.
- R6: Writing ctrlData[2]=1 makes txFlush 1 for exactly the one cycle after the write, and the receive contents are not changed.
- R7: With ctrlData[0]=0 (disabled), the queue holds at most one character and a second push is discarded with an overrun pulse. dataReq follows a threshold of 1 whatever the trigger code.
- R8: ctrlData[5:3] has no effect: a write that sets them behaves the same as one that clears them.
- R9: fifoErr is 1 while the queue is enabled and any stored character has a nonzero flag. It returns to 0 once the last flagged character is read out. It is 0 while the queue is disabled.
- R10: A control write that changes the enable bit also empties the queue, with the same timing as R5.
- R11: A read strobe on an empty queue is ignored. While the queue is empty, hostData and the host flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlData | input | 8 | Control word: [7:6] trigger code, [5:3] unused, [2] transmit flush, [1] receive flush, [0] enable |
| rxValid | input | 1 | Receiver push strobe |
| rxData | input | 8 | Received byte |
| rxParErr | input | 1 | Parity error flag of the received byte |
| rxFrmErr | input | 1 | Framing error flag of the received byte |
| rxBreak | input | 1 | Break flag of the received byte |
| hostRd | input | 1 | Host read strobe, removes the oldest character |
| hostValid | output | 1 | A character is available |
| hostData | output | 8 | Oldest byte |
| hostParErr | output | 1 | Parity flag of the oldest byte |
| hostFrmErr | output | 1 | Framing flag of the oldest byte |
| hostBreak | output | 1 | Break flag of the oldest byte |
| fillLevel | output | 5 | Number of stored characters |
| dataReq | output | 1 | Fill level at or above the trigger threshold |
| fifoErr | output | 1 | Some stored character carries a flag |
| overrun | output | 1 | One-cycle pulse after a discarded push |
| txFlush | output | 1 | One-cycle transmit flush request |

## Verification
The bench builds the block with DEPTH = 16, so all four trigger codes land on the thresholds 1, 4, 8 and 14. A full sweep of fill levels 0 to 16 can therefore be run under every code. Because the depth is small, every push and pop of that sweep can be compared against an arithmetic queue model, including the overflow push and the read on an empty queue. The same model also covers the disabled one-slot mode, the flush paths and the error-flag lifetime.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxq_strobe_t;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } rxq_trig_e;

  function automatic logic entryFlagged(rxq_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [7:0]    ctrlData,
  input  logic          rxValid,
  input  logic          hostRd,
  output rxq_strobe_t   strb,
  output logic [CW-1:0] fillLevel,
  output logic          dataReq,
  output logic          fifoEn,
  output logic          txFlush,
  output logic          overrun
);
  localparam int LVL_QTR  = DEPTH / 4;
  localparam int LVL_HALF = DEPTH / 2;
  localparam int LVL_NEAR = DEPTH - 2;

  logic          enR;
  rxq_trig_e     trigR;
  logic          rxFlushR;
  logic          txFlushR;
  logic          overrunR;
  logic [CW-1:0] countR;
  logic [CW-1:0] capacity;
  logic [CW-1:0] threshold;
  logic          full;

  // control word register with self-clearing flush strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enR      <= 1'b0;
      trigR    <= TRIG_ONE;
      rxFlushR <= 1'b0;
      txFlushR <= 1'b0;
    end else begin
      rxFlushR <= 1'b0;
      txFlushR <= 1'b0;
      if (ctrlWe) begin
        enR      <= ctrlData[0];
        trigR    <= rxq_trig_e'(ctrlData[7:6]);
        rxFlushR <= ctrlData[1] | (ctrlData[0] != enR);
        txFlushR <= ctrlData[2];
      end
    end
  end

  assign capacity = enR ? CW'(DEPTH) : CW'(1);
  assign full     = countR >= capacity;

  always_comb begin
    strb.clear = rxFlushR;
    strb.push  = rxValid && !full && !rxFlushR;
    strb.pop   = hostRd && (countR != '0) && !rxFlushR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countR   <= '0;
      overrunR <= 1'b0;
    end else begin
      overrunR <= rxValid && full && !rxFlushR;
      if (strb.clear) begin
        countR <= '0;
      end else begin
        case ({strb.push, strb.pop})
          2'b10:   countR <= countR + CW'(1);
          2'b01:   countR <= countR - CW'(1);
          default: countR <= countR;
        endcase
      end
    end
  end

  always_comb begin
    if (!enR) begin
      threshold = CW'(1);
    end else begin
      case (trigR)
        TRIG_ONE:  threshold = CW'(1);
        TRIG_QTR:  threshold = CW'(LVL_QTR);
        TRIG_HALF: threshold = CW'(LVL_HALF);
        default:   threshold = CW'(LVL_NEAR);
      endcase
    end
  end

  assign dataReq   = countR >= threshold;
  assign fillLevel = countR;
  assign fifoEn    = enR;
  assign txFlush   = txFlushR;
  assign overrun   = overrunR;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    countR <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && full && !hostRd && !rxFlushR) |=> (overrunR && countR == $past(countR)));

  // R7
  single_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enR && !rxFlushR) |-> countR <= CW'(1));

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFlushR |=> countR == '0);

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFlushR && !ctrlWe) |=> !txFlushR);

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countR == '0 && hostRd && !rxValid && !rxFlushR) |=> countR == '0);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  rxq_strobe_t strb,
  input  rxq_entry_t  wrEntry,
  output rxq_entry_t  headEntry,
  output logic        errAny
);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  rxq_entry_t    slotMem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [AW-1:0] wrNext;
  logic [AW-1:0] rdNext;
  logic [CW-1:0] errCnt;
  logic          wrFlag;
  logic          headFlag;

  // pointer advance: free wrap for power-of-two depth, compare otherwise
  generate
    if (POW2) begin : g_wrap_free
      assign wrNext = wrPtr + AW'(1);
      assign rdNext = rdPtr + AW'(1);
    end else begin : g_wrap_cmp
      assign wrNext = (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      assign rdNext = (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (strb.push && wrPtr == AW'(s)) slotMem[s] <= wrEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrNext;
      if (strb.pop)  rdPtr <= rdNext;
    end
  end

  assign headEntry = slotMem[rdPtr];
  assign wrFlag    = entryFlagged(wrEntry);
  assign headFlag  = entryFlagged(headEntry);

  // tally of stored characters that carry any flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt <= '0;
    end else if (strb.clear) begin
      errCnt <= '0;
    end else begin
      case ({strb.push && wrFlag, strb.pop && headFlag})
        2'b10:   errCnt <= errCnt + CW'(1);
        2'b01:   errCnt <= errCnt - CW'(1);
        default: errCnt <= errCnt;
      endcase
    end
  end

  assign errAny = errCnt != '0;

  // R5
  clear_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (errCnt == '0 && wrPtr == rdPtr));

  // R9
  err_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= CW'(DEPTH));

  // R9
  err_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && headFlag && !strb.push && errCnt == CW'(1)) |=> !errAny);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [7:0]    ctrlData,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          rxParErr,
  input  logic          rxFrmErr,
  input  logic          rxBreak,
  input  logic          hostRd,
  output logic          hostValid,
  output logic [7:0]    hostData,
  output logic          hostParErr,
  output logic          hostFrmErr,
  output logic          hostBreak,
  output logic [CW-1:0] fillLevel,
  output logic          dataReq,
  output logic          fifoErr,
  output logic          overrun,
  output logic          txFlush
);
  rxq_strobe_t strb;
  rxq_entry_t  wrEntry;
  rxq_entry_t  headEntry;
  logic        fifoEn;
  logic        errAny;

  assign wrEntry = '{brk: rxBreak, frm: rxFrmErr, par: rxParErr, data: rxData};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlData  (ctrlData),
    .rxValid   (rxValid),
    .hostRd    (hostRd),
    .strb      (strb),
    .fillLevel (fillLevel),
    .dataReq   (dataReq),
    .fifoEn    (fifoEn),
    .txFlush   (txFlush),
    .overrun   (overrun)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrEntry   (wrEntry),
    .headEntry (headEntry),
    .errAny    (errAny)
  );

  assign hostValid  = fillLevel != '0;
  assign hostData   = hostValid ? headEntry.data : '0;
  assign hostParErr = hostValid & headEntry.par;
  assign hostFrmErr = hostValid & headEntry.frm;
  assign hostBreak  = hostValid & headEntry.brk;
  assign fifoErr    = fifoEn & errAny;
endmodule

// File: tb/rxq_top_test.sv
`timescale 1ns/1ps
module rxq_top_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN;
  logic ctrlWe;
  logic [7:0] ctrlData;
  logic rxValid;
  logic [7:0] rxData;
  logic rxParErr, rxFrmErr, rxBreak;
  logic hostRd;
  logic hostValid;
  logic [7:0] hostData;
  logic hostParErr, hostFrmErr, hostBreak;
  logic [CW-1:0] fillLevel;
  logic dataReq, fifoErr, overrun, txFlush;

  int checks = 0;
  int fails = 0;
  logic [10:0] model[$];
  bit modelEn = 1'b0;
  logic [1:0] curTrig = 2'b00;

  always #10 clk = ~clk;

  rxq_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBreak(rxBreak), .hostRd(hostRd),
    .hostValid(hostValid), .hostData(hostData), .hostParErr(hostParErr),
    .hostFrmErr(hostFrmErr), .hostBreak(hostBreak), .fillLevel(fillLevel),
    .dataReq(dataReq), .fifoErr(fifoErr), .overrun(overrun), .txFlush(txFlush)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thrOf(input logic [1:0] code, input bit en);
    if (!en) return 1;
    case (code)
      2'b00:   return 1;
      2'b01:   return DEPTH / 4;
      2'b10:   return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  function automatic bit anyErr();
    foreach (model[i]) if (model[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [2:0] flagsFor(input int k);
    return (k % 4 == 3) ? 3'(1 << (k % 3)) : 3'b000;
  endfunction

  // every write checks the transmit flush pulse (R6) and the fill level after settling
  task automatic ctrlWrite(input logic [7:0] v, input string tag);
    ctrlWe = 1'b1;
    ctrlData = v;
    @(negedge clk);
    ctrlWe = 1'b0;
    chk("R6 txFlush after write", int'(txFlush), int'(v[2]));
    if (v[1] || (v[0] != modelEn)) model.delete();
    modelEn = v[0];
    curTrig = v[7:6];
    @(negedge clk);
    chk("R6 txFlush one cycle", int'(txFlush), 0);
    chk({tag, " fillLevel after control write"}, int'(fillLevel), model.size());
    chk("R9 fifoErr after control write", int'(fifoErr), int'(modelEn && anyErr()));
  endtask

  task automatic pushOne(input logic [7:0] d, input logic [2:0] fl, input string tag);
    int cap;
    bit drop;
    cap = modelEn ? DEPTH : 1;
    drop = model.size() >= cap;
    rxValid = 1'b1;
    rxData = d;
    {rxBreak, rxFrmErr, rxParErr} = fl;
    @(negedge clk);
    rxValid = 1'b0;
    if (!drop) model.push_back({fl, d});
    chk("R4 overrun", int'(overrun), int'(drop));
    chk({tag, " fillLevel"}, int'(fillLevel), model.size());
    chk("R3 dataReq", int'(dataReq), int'(model.size() >= thrOf(curTrig, modelEn)));
    chk("R9 fifoErr", int'(fifoErr), int'(modelEn && anyErr()));
  endtask

  task automatic popOne(input string tag);
    if (model.size() > 0) begin
      chk("R2 hostValid", int'(hostValid), 1);
      chk("R2 hostData", int'(hostData), int'(model[0][7:0]));
      chk("R2 flags", int'({hostBreak, hostFrmErr, hostParErr}), int'(model[0][10:8]));
    end else begin
      chk("R11 hostValid empty", int'(hostValid), 0);
      chk("R11 hostData empty", int'({hostBreak, hostFrmErr, hostParErr, hostData}), 0);
    end
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    if (model.size() > 0) void'(model.pop_front());
    chk({tag, " fillLevel after read"}, int'(fillLevel), model.size());
    chk("R9 fifoErr after read", int'(fifoErr), int'(modelEn && anyErr()));
    chk("R3 dataReq after read", int'(dataReq), int'(model.size() >= thrOf(curTrig, modelEn)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; ctrlWe = 1'b0; ctrlData = '0; rxValid = 1'b0; rxData = '0;
    rxParErr = 1'b0; rxFrmErr = 1'b0; rxBreak = 1'b0; hostRd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fillLevel", int'(fillLevel), 0);
    chk("R1 dataReq", int'(dataReq), 0);
    chk("R1 fifoErr", int'(fifoErr), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 txFlush", int'(txFlush), 0);
    chk("R1 hostValid", int'(hostValid), 0);

    // R3 sweep of every trigger code across all fill levels, R2 order, R4 overflow
    for (int code = 0; code < 4; code++) begin
      ctrlWrite({2'(code), 3'b000, 1'b0, 1'b1, 1'b1}, "R5");
      for (int k = 1; k <= DEPTH; k++) pushOne(8'(code * 40 + k), flagsFor(k), "R2");
      pushOne(8'hEE, 3'b111, "R4");
      @(negedge clk);
      chk("R4 overrun clears", int'(overrun), 0);
      chk("R4 fillLevel kept", int'(fillLevel), DEPTH);
      for (int k = 1; k <= DEPTH; k++) popOne("R2");
      popOne("R11");
    end

    // R8 unused control bits
    ctrlWrite(8'h03, "R5");
    pushOne(8'h11, 3'b000, "R8");
    pushOne(8'h12, 3'b000, "R8");
    ctrlWrite(8'b01_111_001, "R8");
    pushOne(8'h13, 3'b000, "R8");
    pushOne(8'h14, 3'b010, "R8");

    // R6 transmit flush leaves receive contents alone
    ctrlWrite(8'h45, "R6");
    popOne("R6");

    // R5 receive flush with a flagged entry present
    pushOne(8'h15, 3'b100, "R5");
    ctrlWrite(8'h43, "R5");
    pushOne(8'h16, 3'b000, "R5");
    @(negedge clk);
    chk("R5 flush self-clears", int'(fillLevel), 1);

    // R10 disable empties the queue
    pushOne(8'h17, 3'b000, "R10");
    pushOne(8'h18, 3'b000, "R10");
    ctrlWrite(8'hC0, "R10");

    // R7 single holding slot while disabled
    pushOne(8'h21, 3'b001, "R7");
    pushOne(8'h22, 3'b000, "R7");
    popOne("R7");
    popOne("R11");
    pushOne(8'h23, 3'b000, "R7");
    popOne("R7");

    // R10 re-enable flushes, then near-full trigger
    pushOne(8'h24, 3'b000, "R7");
    ctrlWrite(8'hC1, "R10");
    for (int k = 1; k <= DEPTH - 1; k++) pushOne(8'(k + 100), flagsFor(k + 1), "R3");
    for (int k = 1; k <= DEPTH - 1; k++) popOne("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule